// File: doc/BRIEF.md
# Crystal Clock Supervisor with Reference Fallback

This block watches a main crystal clock against an internal reference clock that never stops. The reference is divided by five. Rising edges of the main clock are counted over a window of `WIN_LEN` divided-reference periods. If the main clock runs slower than the divided reference, or has stopped or never started, the block moves the system clock onto the reference. In the same cycle it raises the system reset. It also sets a sticky flag that records the oscillator failure.

A second sticky flag records watchdog-timer trips. Resets caused by an oscillator fault do not clear it, so software that runs after the fault can still find an earlier timer trip. The timer itself is held stopped, because it sits under the system reset. While the block runs on the reference, it keeps counting main-clock edges. When a window shows the crystal running again, the block holds reset and the reference clock for `STAB_CYC` further reference cycles, so the crystal can settle. It then hands the clock back to the crystal and releases reset. After an external reset the block starts on the reference and follows the same recovery path.

The selected clock reaches the system through a divide-by-two stage. Each source has its own enable, and the two enables hand over break-before-make. If the crystal is dead, it cannot clock its own enable off. A timeout clears that enable directly.

Top module: `osc_guard`

## Requirements
- R1: While `rst_n` is low, `on_ref` and `sys_rst` are 1 and `osc_fail` and `wdt_seen` are 0.
- R2: Clock-source and reset decisions change only at window ends. A window is `REF_DIV*WIN_LEN` reference cycles long. The first window ends on the `REF_DIV*WIN_LEN`-th rising reference edge after `rst_n` is released, and the following windows end every `REF_DIV*WIN_LEN` edges after that.
- R3: While on the crystal (`on_ref`=0), a window with fewer than `WIN_LEN` main-clock rising edges raises `on_ref` and `sys_rst` together at that window's end. This applies both to a stopped main clock and to one that is merely too slow.
- R4: `osc_fail` goes to 1 in the same cycle as the switch of R3 and stays 1 until `rst_n` is driven low.
- R5: A 1 on `wdt_trip` at a rising reference edge sets `wdt_seen`. Only `rst_n` clears it; resets caused by an oscillator failure leave it at 1.
- R6: While on the reference, a window with at least `WIN_LEN+1` main edges starts the settling period. `on_ref` and `sys_rst` then stay 1 for exactly `STAB_CYC` more reference edges and fall together on the `STAB_CYC`-th edge after that window's end. A too-slow main clock never starts the settling period.
- R7: A window with fewer than `WIN_LEN` edges that ends during the settling period cancels it. The next good window starts a full `STAB_CYC` period again.
- R8: `clk_sys` toggles on each rising edge of the selected source: the reference while switched away, the crystal otherwise. The two source enables are never both on. The crystal enable is forced off `KILL_CYC` reference cycles after a switch if the crystal cannot clear it itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-running reference clock; all supervision logic runs on it |
| clk_main | input | 1 | Main crystal clock under supervision |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wdt_trip | input | 1 | Watchdog-timer trip pulse, reference domain |
| clk_sys | output | 1 | Selected clock divided by two |
| sys_rst | output | 1 | System reset, active high (external or oscillator) |
| on_ref | output | 1 | 1 while the system clock is taken from the reference |
| osc_fail | output | 1 | Sticky oscillator-failure flag |
| wdt_seen | output | 1 | Sticky watchdog-trip flag, kept through oscillator resets |

## Verification
The hardest condition to reach is a bad window that ends inside the settling period. The crystal has to recover for exactly one window and then stop again before `STAB_CYC` runs out. The stimulus tracks window boundaries from the reset release and changes the crystal's mode only just after a boundary, so every window sees one clean mode. It then restarts the crystal one window after the cancel and checks that the release comes a full settling period later. Forcing the crystal enable off is exercised by stopping the crystal outright. A slow crystal exercises the path where the crystal clears its own enable.

// File: rtl/osc_guard.sv
module osc_guard #(
  parameter int REF_DIV  = 5,
  parameter int WIN_LEN  = 16,
  parameter int STAB_CYC = 3000,
  parameter int KILL_CYC = 32
) (
  input  logic clk_ref,
  input  logic clk_main,
  input  logic rst_n,
  input  logic wdt_trip,
  output logic clk_sys,
  output logic sys_rst,
  output logic on_ref,
  output logic osc_fail,
  output logic wdt_seen
);

  localparam int DW = $clog2(REF_DIV);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int CW = $clog2(WIN_LEN + 2);
  localparam int SW = $clog2(STAB_CYC + 1);
  localparam int KW = $clog2(KILL_CYC + 1);
  localparam logic [DW-1:0] DIV_TOP  = DW'(REF_DIV - 1);
  localparam logic [WW-1:0] WIN_TOP  = WW'(WIN_LEN - 1);
  localparam logic [CW-1:0] CNT_LOW  = CW'(WIN_LEN);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WIN_LEN + 1);
  localparam logic [SW-1:0] STAB_TOP = SW'(STAB_CYC - 1);
  localparam logic [KW-1:0] KILL_TOP = KW'(KILL_CYC - 1);

  typedef enum logic [1:0] {S_RUN, S_DOWN, S_STAB} st_t;

  st_t           state, st_nx;
  logic [DW-1:0] div_cnt;
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] edge_cnt;
  logic [SW-1:0] stab_cnt;
  logic [KW-1:0] kill_cnt;
  logic          kill_q;
  logic          m_tog;
  logic [2:0]    m_smp;
  logic [1:0]    sel_dly;
  logic [1:0]    mm;
  logic [1:0]    mb;
  logic          en_ref;
  logic          sel_ref_q;
  logic          clk_sys_q;

  // main-clock edge sampling
  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) m_tog <= 1'b0;
    else        m_tog <= ~m_tog;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) m_smp <= '0;
    else        m_smp <= {m_smp[1:0], m_tog};

  wire m_edge = m_smp[2] ^ m_smp[1];

  // window timing: WIN_LEN periods of clk_ref / REF_DIV
  wire div_wrap = (div_cnt == DIV_TOP);
  wire win_end  = div_wrap && (win_cnt == WIN_TOP);

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      win_cnt <= '0;
    end else begin
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      if (div_wrap) win_cnt <= (win_cnt == WIN_TOP) ? '0 : win_cnt + 1'b1;
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)                            edge_cnt <= '0;
    else if (win_end)                      edge_cnt <= CW'(m_edge);
    else if (m_edge && edge_cnt != CNT_SAT) edge_cnt <= edge_cnt + 1'b1;

  wire slow      = edge_cnt < CNT_LOW;
  wire good      = edge_cnt == CNT_SAT;
  wire stab_done = (stab_cnt == STAB_TOP);

  // supervision sequence
  always_comb begin
    st_nx = state;
    case (state)
      S_RUN:   if (win_end && slow) st_nx = S_DOWN;
      S_DOWN:  if (win_end && good) st_nx = S_STAB;
      S_STAB:  if (win_end && slow) st_nx = S_DOWN;
               else if (stab_done)  st_nx = S_RUN;
      default: st_nx = S_DOWN;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      state     <= S_DOWN;
      stab_cnt  <= '0;
      sel_ref_q <= 1'b1;
      osc_fail  <= 1'b0;
      wdt_seen  <= 1'b0;
    end else begin
      state     <= st_nx;
      stab_cnt  <= (state == S_STAB && st_nx == S_STAB) ? stab_cnt + 1'b1 : '0;
      sel_ref_q <= (st_nx != S_RUN);
      osc_fail  <= osc_fail | (state == S_RUN && st_nx == S_DOWN);
      wdt_seen  <= wdt_seen | wdt_trip;
    end

  assign on_ref  = sel_ref_q;
  assign sys_rst = sel_ref_q | ~rst_n;

  // break-before-make source handover
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      sel_dly <= 2'b11;
      mb      <= 2'b00;
    end else begin
      sel_dly <= {sel_dly[0], sel_ref_q};
      mb      <= {mb[0], mm[0] | mm[1]};
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      kill_cnt <= '0;
      kill_q   <= 1'b0;
    end else if (!sel_ref_q) begin
      kill_cnt <= '0;
      kill_q   <= 1'b0;
    end else if (mb[1] && !kill_q) begin
      if (kill_cnt == KILL_TOP) kill_q <= 1'b1;
      else                      kill_cnt <= kill_cnt + 1'b1;
    end

  always_ff @(negedge clk_ref or negedge rst_n)
    if (!rst_n) en_ref <= 1'b0;
    else        en_ref <= sel_ref_q & sel_dly[1] & ~mb[1];

  wire m_go  = ~sel_ref_q & ~en_ref;
  wire m_clr = ~rst_n | kill_q;

  always_ff @(negedge clk_main or posedge m_clr)
    if (m_clr) mm <= 2'b00;
    else       mm <= {mm[0], m_go};

  wire en_main = mm[1];
  wire clk_mux = (clk_main & en_main) | (clk_ref & en_ref);

  always_ff @(posedge clk_mux or negedge rst_n)
    if (!rst_n) clk_sys_q <= 1'b0;
    else        clk_sys_q <= ~clk_sys_q;

  assign clk_sys = clk_sys_q;

endmodule

// File: rtl/osc_guard_chk.sv
module osc_guard_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic on_ref,
  input logic osc_fail,
  input logic wdt_seen,
  input logic en_main,
  input logic en_ref,
  input logic win_end,
  input logic stab_done
);

  p_no_overlap_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(en_main && en_ref));

  p_switch_at_window_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(on_ref) |-> $past(win_end));

  p_fail_flag_set_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(on_ref) |-> osc_fail);

  p_fail_flag_hold_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    osc_fail |=> osc_fail);

  p_wdt_hold_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    wdt_seen |=> wdt_seen);

  p_release_after_settle_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(on_ref) |-> $past(stab_done));

endmodule

bind osc_guard osc_guard_chk u_chk (
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .on_ref   (on_ref),
  .osc_fail (osc_fail),
  .wdt_seen (wdt_seen),
  .en_main  (en_main),
  .en_ref   (en_ref),
  .win_end  (win_end),
  .stab_done(stab_done)
);

// File: tb/tb_osc_guard.sv
`timescale 1ns/1ps
module tb_osc_guard;

  localparam int W    = 8;
  localparam int STAB = 100;
  localparam int KILL = 16;
  localparam int P    = 5 * W;

  logic clk_ref, clk_main, rst_n, wdt_trip;
  logic clk_sys, sys_rst, on_ref, osc_fail, wdt_seen;

  osc_guard #(.REF_DIV(5), .WIN_LEN(W), .STAB_CYC(STAB), .KILL_CYC(KILL)) dut (
    .clk_ref(clk_ref), .clk_main(clk_main), .rst_n(rst_n), .wdt_trip(wdt_trip),
    .clk_sys(clk_sys), .sys_rst(sys_rst), .on_ref(on_ref),
    .osc_fail(osc_fail), .wdt_seen(wdt_seen));

  int tests = 0, fails = 0;
  int mode  = 2;
  int k     = 0;
  int mst   = 1;
  int scnt  = 0;
  bit m_fail = 0, m_wdt = 0;
  int sys_edges = 0;
  int ph = 0;

  initial begin clk_ref = 0; forever #4 clk_ref = ~clk_ref; end

  initial begin
    clk_main = 0;
    forever begin
      @(negedge clk_ref);
      ph++;
      if (mode == 2) clk_main = ~clk_main;
      else if (mode == 1 && ph % 5 == 0) clk_main = ~clk_main;
    end
  end

  always @(posedge clk_sys) sys_edges++;

  // behavioural reference: 0 run, 1 waiting, 2 settling
  always @(posedge clk_ref) begin
    if (!rst_n) begin
      k = 0; mst = 1; scnt = 0; m_fail = 0; m_wdt = 0;
    end else begin
      k++;
      if (wdt_trip) m_wdt = 1;
      if (k % P == 0) begin
        if (mst == 0 && mode != 2) begin mst = 1; m_fail = 1; end
        else if (mst == 1 && mode == 2) begin mst = 2; scnt = 0; end
        else if (mst == 2 && mode != 2) mst = 1;
        else if (mst == 2) begin if (scnt == STAB - 1) mst = 0; else scnt++; end
      end else if (mst == 2) begin
        if (scnt == STAB - 1) mst = 0; else scnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_ref) begin
    #1;
    check(on_ref === (!rst_n || mst != 0), "R2 R3 R6 on_ref", on_ref, (!rst_n || mst != 0));
    check(sys_rst === (!rst_n || mst != 0), "R3 R6 sys_rst", sys_rst, (!rst_n || mst != 0));
    check(osc_fail === (rst_n && m_fail), "R4 osc_fail", osc_fail, (rst_n && m_fail));
    check(wdt_seen === (rst_n && m_wdt), "R5 wdt_seen", wdt_seen, (rst_n && m_wdt));
  end

  task automatic wait_bnd(input int n);
    for (int i = 0; i < n; i++)
      do @(negedge clk_ref); while (k == 0 || k % P != 0);
  endtask

  task automatic wait_k(input int target);
    while (k < target) @(negedge clk_ref);
  endtask

  task automatic measure(input int exp, input string tag);
    int e0 = sys_edges;
    repeat (P) @(negedge clk_ref);
    check((sys_edges - e0 >= exp - 1) && (sys_edges - e0 <= exp + 1), tag, sys_edges - e0, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk_ref);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int b;
    rst_n = 0; wdt_trip = 0; mode = 2;
    repeat (3) @(negedge clk_ref);
    #1;
    check(on_ref && sys_rst && !osc_fail && !wdt_seen, "R1 reset state", {on_ref, sys_rst, osc_fail, wdt_seen}, 4'b1100);
    @(negedge clk_ref); rst_n = 1;

    // start-up settling, R2 first window and R6 release timing
    wait_k(P - 1);
    check(on_ref == 1, "R2 before first window", on_ref, 1);
    wait_k(P + STAB - 1);
    check(on_ref == 1 && sys_rst == 1, "R6 held one edge before release", on_ref, 1);
    @(negedge clk_ref);
    check(on_ref == 0 && sys_rst == 0, "R6 released", on_ref, 0);

    repeat (10) @(negedge clk_ref);
    measure(P / 4, "R8 clk_sys on crystal");

    @(negedge clk_ref); wdt_trip = 1;
    @(negedge clk_ref); wdt_trip = 0;
    check(wdt_seen == 1, "R5 trip sets flag", wdt_seen, 1);

    // stopped crystal
    wait_bnd(1); mode = 0; b = k;
    wait_k(b + P - 1);
    check(on_ref == 0, "R2 no switch inside window", on_ref, 0);
    @(negedge clk_ref);
    check(on_ref && sys_rst && osc_fail, "R3 R4 stop detected", {on_ref, sys_rst, osc_fail}, 3'b111);
    check(wdt_seen == 1, "R5 kept through oscillator reset", wdt_seen, 1);
    repeat (P) @(negedge clk_ref);
    measure(P / 2, "R8 clk_sys on reference after forced release");

    // slow crystal does not recover
    wait_bnd(1); mode = 1;
    wait_bnd(2);
    check(on_ref == 1, "R6 slow crystal stays on reference", on_ref, 1);

    // recovery, cancelled settling, recovery again
    mode = 2; b = k;
    wait_bnd(1); mode = 0;
    wait_bnd(1); mode = 2;
    wait_k(b + 3 * P + STAB - P);
    check(on_ref == 1, "R7 cancelled settling keeps reset", on_ref, 1);
    wait_k(b + 3 * P + STAB - 1);
    check(on_ref == 1, "R7 full period restarts", on_ref, 1);
    @(negedge clk_ref);
    check(on_ref == 0 && sys_rst == 0, "R7 R6 release after restart", on_ref, 0);

    // slow crystal while running
    wait_bnd(1); mode = 1;
    wait_bnd(1);
    check(on_ref == 1 && osc_fail == 1, "R3 slow crystal detected", on_ref, 1);

    // external reset clears both flags
    @(negedge clk_ref); rst_n = 0; mode = 2;
    #1;
    check(!osc_fail && !wdt_seen && on_ref, "R1 R4 R5 flags cleared", {osc_fail, wdt_seen}, 0);
    repeat (3) @(negedge clk_ref); rst_n = 1;
    wait_k(P + STAB + 2);
    check(on_ref == 0 && osc_fail == 0, "R6 restart after external reset", on_ref, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule